// File: doc/BRIEF.md
# Privilege-Gated Flag Word Guard

This block keeps the 16-bit processor status word and decides, one instruction at a time, whether the current privilege level (CPL) allows that instruction. The decoder presents an instruction class, the CPL and, for a flag-restore instruction, the value to restore. On the next clock edge the block either updates the flag word or raises a one-cycle fault pulse carrying vector 13 and a zero error code. Flag-restore instructions never fault. Instead, fields the caller may not touch silently keep their old values. The I/O privilege level (IOPL) is read from flag bits 13:12, the interrupt-enable flag is bit 9, and bit 14 is the nested-task bit.

The control is a three-state machine that records the outcome of the last accepted instruction. `ST_IDLE` means that no instruction was taken. `ST_APPLY` means the flag word was committed. `ST_FAULT` means the instruction was refused. Each cycle the machine moves to one of these three states. The choice depends on the instruction strobe, the class, and the privilege gate's verdict:
- no strobe, or an inert class, goes to `ST_IDLE`;
- an allowed class goes to `ST_APPLY`;
- a denied class goes to `ST_FAULT`.

These transitions are called `T_NONE`, `T_COMMIT` and `T_DENY`. They can be taken from any state.

Top module: `priv_flag_guard`

## Requirements
- R1: While reset is high, the flag word is cleared to 0x0002 on each clock edge. During reset, `fault_pulse` is low and `fault_vector` is 0.
- R2: A restore (class 1) at CPL 0 loads all 16 bits of `restore_val`, including the nested-task bit 14.
- R3: A restore with CPL numerically greater than the current IOPL keeps the old bit 9 (interrupt enable).
- R4: A restore with CPL greater than 0 keeps the old bits 13:12 (IOPL). All bits outside the suppressed fields load from `restore_val`.
- R5: A restore never raises `fault_pulse`, whatever the CPL and IOPL.
- R6: A system-control instruction (class 2: descriptor-table loads, task register load, machine status load, clear task-switched, halt) faults exactly when CPL is not 0.
- R7: Port I/O or bus lock (class 3), set-interrupt (class 4) and clear-interrupt (class 5) fault exactly when CPL is greater than the current IOPL.
- R8: The fault is reported in the cycle after the instruction is presented: `fault_pulse` goes high for one cycle, `fault_vector` is 13 and `fault_code` is 0. When no instruction follows, `fault_pulse` is low one cycle later. A faulting instruction leaves the flag word unchanged.
- R9: When allowed, class 4 sets bit 9 and class 5 clears bit 9. All other bits keep their values.
- R10: With `ins_valid` low, or with class 0, 6 or 7, the flag word does not change and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | An instruction is presented this cycle |
| ins_class | input | 3 | Instruction class code (0 inert, 1 restore, 2 system, 3 port/lock, 4 set IF, 5 clear IF, 6-7 inert) |
| cpl | input | 2 | Current privilege level |
| restore_val | input | 16 | Flag value for a restore instruction |
| flags_q | output | 16 | Current flag word |
| fault_pulse | output | 1 | One-cycle fault strobe |
| fault_vector | output | 8 | Exception vector (13 with a fault, else 0) |
| fault_code | output | 16 | Error code pushed with the fault (always 0) |

## Verification
The bench uses the default parameters: a 16-bit flag word, a 2-bit privilege level and a 3-bit class code. With these values, the whole decision space is small enough to sweep in full. The sweep covers every IOPL, each value of the interrupt-enable bit, every CPL and all eight class codes, so every pairing of CPL with IOPL and every inert code is reached. The restore values are patterned so that each suppressed field differs from the flag word already held. That way, any wrong mask shows up in the flag word.

// File: rtl/priv_flag_pkg.sv
package priv_flag_pkg;

    localparam int CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_NONE    = 3'd0,
        CLS_RESTORE = 3'd1,
        CLS_SYSTEM  = 3'd2,
        CLS_PORTIO  = 3'd3,
        CLS_SETIF   = 3'd4,
        CLS_CLRIF   = 3'd5,
        CLS_RSVD6   = 3'd6,
        CLS_RSVD7   = 3'd7
    } ins_class_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_APPLY = 2'd1,
        ST_FAULT = 2'd2
    } guard_state_e;

    typedef struct packed {
        logic acts;
        logic allow;
    } verdict_t;

endpackage

// File: rtl/pfg_gate.sv
module pfg_gate
    import priv_flag_pkg::*;
#(
    parameter int PL_W = 2
) (
    input  logic [CLS_W-1:0] cls,
    input  logic [PL_W-1:0]  cur_pl,
    input  logic [PL_W-1:0]  io_pl,
    output verdict_t         verdict
);

    logic io_denied;
    logic sys_denied;

    assign io_denied  = (cur_pl > io_pl);
    assign sys_denied = (cur_pl != '0);

    always_comb begin
        verdict.acts  = 1'b0;
        verdict.allow = 1'b1;
        unique case (cls)
            CLS_RESTORE: begin
                verdict.acts  = 1'b1;
                verdict.allow = 1'b1;
            end
            CLS_SYSTEM: begin
                verdict.acts  = 1'b1;
                verdict.allow = !sys_denied;
            end
            CLS_PORTIO, CLS_SETIF, CLS_CLRIF: begin
                verdict.acts  = 1'b1;
                verdict.allow = !io_denied;
            end
            CLS_NONE, CLS_RSVD6, CLS_RSVD7: begin
                verdict.acts  = 1'b0;
                verdict.allow = 1'b1;
            end
            default: begin
                verdict.acts  = 1'b0;
                verdict.allow = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pfg_merge.sv
module pfg_merge
    import priv_flag_pkg::*;
#(
    parameter int FLAG_W  = 16,
    parameter int PL_W    = 2,
    parameter int IE_POS  = 9,
    parameter int IOPL_LO = 12
) (
    input  logic [CLS_W-1:0]  cls,
    input  logic [PL_W-1:0]   cur_pl,
    input  logic [FLAG_W-1:0] old_flags,
    input  logic [FLAG_W-1:0] new_flags,
    output logic [FLAG_W-1:0] merged
);

    localparam int IOPL_HI = IOPL_LO + PL_W - 1;

    logic [PL_W-1:0]   io_pl;
    logic              keep_ie;
    logic              keep_iopl;
    logic [FLAG_W-1:0] keep_mask;
    logic [FLAG_W-1:0] restored;

    assign io_pl     = old_flags[IOPL_HI:IOPL_LO];
    assign keep_ie   = (cur_pl > io_pl);
    assign keep_iopl = (cur_pl != '0);

    for (genvar b = 0; b < FLAG_W; b++) begin : g_mask
        if (b == IE_POS) begin : g_ie
            assign keep_mask[b] = keep_ie;
        end else if (b >= IOPL_LO && b <= IOPL_HI) begin : g_iopl
            assign keep_mask[b] = keep_iopl;
        end else begin : g_free
            assign keep_mask[b] = 1'b0;
        end
    end

    assign restored = (old_flags & keep_mask) | (new_flags & ~keep_mask);

    always_comb begin
        merged = old_flags;
        unique case (cls)
            CLS_RESTORE: merged = restored;
            CLS_SETIF:   merged[IE_POS] = 1'b1;
            CLS_CLRIF:   merged[IE_POS] = 1'b0;
            default:     merged = old_flags;
        endcase
    end

endmodule

// File: rtl/priv_flag_guard.sv
module priv_flag_guard
    import priv_flag_pkg::*;
#(
    parameter int              FLAG_W    = 16,
    parameter int              PL_W      = 2,
    parameter int              IE_POS    = 9,
    parameter int              IOPL_LO   = 12,
    parameter int              VEC_W     = 8,
    parameter int              GP_VECTOR = 13,
    parameter int              CODE_W    = 16,
    parameter logic [15:0]     RST_FLAGS = 16'h0002
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ins_valid,
    input  logic [CLS_W-1:0]    ins_class,
    input  logic [PL_W-1:0]     cpl,
    input  logic [FLAG_W-1:0]   restore_val,
    output logic [FLAG_W-1:0]   flags_q,
    output logic                fault_pulse,
    output logic [VEC_W-1:0]    fault_vector,
    output logic [CODE_W-1:0]   fault_code
);

    localparam int IOPL_HI = IOPL_LO + PL_W - 1;
    localparam logic [VEC_W-1:0] VEC_VAL = VEC_W'(GP_VECTOR);

    guard_state_e      state_q, state_d;
    verdict_t          verdict;
    logic [FLAG_W-1:0] merged;
    logic [PL_W-1:0]   io_pl;

    assign io_pl = flags_q[IOPL_HI:IOPL_LO];

    pfg_gate #(.PL_W(PL_W)) gate_i (
        .cls     (ins_class),
        .cur_pl  (cpl),
        .io_pl   (io_pl),
        .verdict (verdict)
    );

    pfg_merge #(
        .FLAG_W  (FLAG_W),
        .PL_W    (PL_W),
        .IE_POS  (IE_POS),
        .IOPL_LO (IOPL_LO)
    ) merge_i (
        .cls       (ins_class),
        .cur_pl    (cpl),
        .old_flags (flags_q),
        .new_flags (restore_val),
        .merged    (merged)
    );

    // next-state: T_NONE / T_COMMIT / T_DENY from any state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_APPLY, ST_FAULT: begin
                if (!ins_valid || !verdict.acts)
                    state_d = ST_IDLE;
                else if (verdict.allow)
                    state_d = ST_APPLY;
                else
                    state_d = ST_FAULT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= FLAG_W'(RST_FLAGS);
        else if (state_d == ST_APPLY)
            flags_q <= merged;
    end

    always_comb begin
        fault_pulse  = 1'b0;
        fault_vector = '0;
        fault_code   = '0;
        unique case (state_q)
            ST_FAULT: begin
                fault_pulse  = 1'b1;
                fault_vector = VEC_VAL;
            end
            ST_IDLE, ST_APPLY: begin
                fault_pulse  = 1'b0;
                fault_vector = '0;
            end
            default: begin
                fault_pulse  = 1'b0;
                fault_vector = '0;
            end
        endcase
    end

    // R5: restores never fault
    p_restore_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && ins_class == CLS_RESTORE) |=> !fault_pulse);

    // R6: system class at nonzero CPL faults with vector 13
    p_sys_fault_r6: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && ins_class == CLS_SYSTEM && cpl != '0) |=>
        (fault_pulse && fault_vector == VEC_VAL));

    // R8: faulting instruction leaves flags untouched
    p_fault_holds_flags_r8: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |-> flags_q == $past(flags_q));

    // R8: a fault only follows a presented instruction
    p_fault_after_ins_r8: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |-> $past(ins_valid));

    // R4: IOPL field protected above CPL 0
    p_iopl_kept_r4: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && ins_class == CLS_RESTORE && cpl != '0) |=>
        flags_q[IOPL_HI:IOPL_LO] == $past(flags_q[IOPL_HI:IOPL_LO]));

    // R3: interrupt enable protected when CPL > IOPL
    p_ie_kept_r3: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && ins_class == CLS_RESTORE && cpl > io_pl) |=>
        $stable(flags_q[IE_POS]));

    // R10: no strobe means no change and no fault
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !ins_valid |=> (!fault_pulse && $stable(flags_q)));

endmodule

// File: tb/priv_flag_guard_tb.sv
module priv_flag_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        ins_valid;
    logic [2:0]  ins_class;
    logic [1:0]  cpl;
    logic [15:0] restore_val;
    logic [15:0] flags_q;
    logic        fault_pulse;
    logic [7:0]  fault_vector;
    logic [15:0] fault_code;

    int checks = 0;
    int fails  = 0;
    logic [15:0] exp_flags;

    always #2.5 clk = ~clk;

    priv_flag_guard dut_i (
        .clk          (clk),
        .rst          (rst),
        .ins_valid    (ins_valid),
        .ins_class    (ins_class),
        .cpl          (cpl),
        .restore_val  (restore_val),
        .flags_q      (flags_q),
        .fault_pulse  (fault_pulse),
        .fault_vector (fault_vector),
        .fault_code   (fault_code)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] c, input logic [1:0] p, input logic [15:0] v);
        logic [1:0]  iopl;
        logic        deny;
        logic [15:0] nxt;
        iopl = exp_flags[13:12];
        deny = 1'b0;
        nxt  = exp_flags;
        case (c)
            3'd1: begin
                nxt = v;
                if (p > iopl) nxt[9] = exp_flags[9];
                if (p != 0)   nxt[13:12] = exp_flags[13:12];
            end
            3'd2: deny = (p != 0);
            3'd3: deny = (p > iopl);
            3'd4: begin deny = (p > iopl); nxt[9] = 1'b1; end
            3'd5: begin deny = (p > iopl); nxt[9] = 1'b0; end
            default: ;
        endcase
        if (deny) nxt = exp_flags;
        @(negedge clk);
        ins_valid = 1'b1; ins_class = c; cpl = p; restore_val = v;
        @(negedge clk);
        ins_valid = 1'b0;
        case (c)
            3'd1: check("R2/R3/R4 restore flags", {16'h0, flags_q}, {16'h0, nxt});
            3'd2: check("R6 system flags", {16'h0, flags_q}, {16'h0, nxt});
            3'd4, 3'd5: check("R9 IF set/clear flags", {16'h0, flags_q}, {16'h0, nxt});
            3'd3: check("R7 port flags", {16'h0, flags_q}, {16'h0, nxt});
            default: check("R10 inert flags", {16'h0, flags_q}, {16'h0, nxt});
        endcase
        if (c == 3'd1)      check("R5 restore no fault", {31'h0, fault_pulse}, 32'h0);
        else if (c == 3'd2) check("R6 system fault", {31'h0, fault_pulse}, {31'h0, deny});
        else if (c >= 3'd3 && c <= 3'd5) check("R7 io fault", {31'h0, fault_pulse}, {31'h0, deny});
        else                check("R10 inert no fault", {31'h0, fault_pulse}, 32'h0);
        check("R8 vector", {24'h0, fault_vector}, deny ? 32'd13 : 32'd0);
        check("R8 code", {16'h0, fault_code}, 32'h0);
        exp_flags = nxt;
        if (deny) begin
            @(negedge clk);
            check("R8 pulse one cycle", {31'h0, fault_pulse}, 32'h0);
            check("R8 flags held", {16'h0, flags_q}, {16'h0, exp_flags});
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; ins_valid = 1'b0; ins_class = 3'd0; cpl = 2'd0; restore_val = 16'h0;
        repeat (3) @(negedge clk);
        check("R1 reset flags", {16'h0, flags_q}, 32'h0002);
        check("R1 reset fault", {31'h0, fault_pulse}, 32'h0);
        check("R1 reset vector", {24'h0, fault_vector}, 32'h0);
        rst = 1'b0;
        exp_flags = 16'h0002;
        @(negedge clk);
        check("R10 idle after reset", {16'h0, flags_q}, 32'h0002);

        for (int iopl = 0; iopl < 4; iopl++) begin
            for (int ie = 0; ie < 2; ie++) begin
                for (int p = 0; p < 4; p++) begin
                    for (int c = 0; c < 8; c++) begin
                        logic [15:0] seed;
                        seed = 16'h48A6 ^ 16'(p * 16'h0111) ^ 16'(c * 16'h2008);
                        seed[13:12] = 2'(iopl);
                        seed[9] = 1'(ie);
                        do_op(3'd1, 2'd0, seed);
                        do_op(3'(c), 2'(p), ~seed);
                    end
                end
            end
        end

        // R10: strobe low with an active class
        @(negedge clk);
        ins_valid = 1'b0; ins_class = 3'd1; cpl = 2'd0; restore_val = ~exp_flags;
        @(negedge clk);
        check("R10 no strobe flags", {16'h0, flags_q}, {16'h0, exp_flags});
        check("R10 no strobe fault", {31'h0, fault_pulse}, 32'h0);

        // R1: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 re-reset flags", {16'h0, flags_q}, 32'h0002);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule